// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Write Arbitration

A single-clock memory with two symmetric ports, A and B. Each port has its own address, write data, write enable, read enable, per-lane byte enables and an address stall, and each port returns its own registered read data. Both ports can work in the same cycle in any combination: two reads, two writes, or one of each. The bare storage array has no way to settle two writes to one word, so a small resolver in front of it splits the byte lanes between the ports. A whole word is therefore always written with well-defined contents.

When both ports write the same word in the same cycle, port A takes every lane it enables and port B fills only the lanes A leaves off. A one-cycle collision pulse reports each such event. A port that reads a word the other port is writing sees the contents from before the edge. A port that reads the word it is writing itself follows its own mode parameter: either the contents after the write, or the contents before it. The address stall freezes a port's address, so the port repeats its last location whatever its address input carries.

Top module: `tdp_ram_arb`

## Requirements
- R1: While `rst_n` is low, `a_rdata`, `b_rdata` and `coll_o` are all zero.
- R2: With read enable high, a port's read data shows, one clock after the edge, the word stored at its effective address before that edge. This holds unless R8 applies.
- R3: Byte-enable bit i selects lane i, which is data bits [i*LANE_W +: LANE_W]. Lanes whose enable bit is 0 keep their stored value.
- R4: While a port's read enable is low, its read data keeps its previous value, including in cycles when that port writes.
- R5: When both ports write the same effective address in one cycle, the stored word takes port A's data in every lane A enables. It takes port B's data in lanes B enables and A does not. All other lanes keep their old value.
- R6: `coll_o` is high for exactly the cycle after a cycle in which both write enables were high at equal effective addresses. Otherwise it is low. The byte enables do not affect it.
- R7: A port that reads an address the other port writes in the same cycle returns the value from before the write.
- R8: A port that writes and reads in the same cycle returns the word's contents after the edge when its mode is RDW_NEW. It returns the contents from before the edge when its mode is RDW_OLD. The defaults are A = RDW_NEW and B = RDW_OLD.
- R9: While a port's stall input is high, that port reads and writes at the effective address it used in the previous cycle, and its address input is ignored. After reset that address is 0.
- R10: Writes from the two ports to different addresses in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset of the address and output registers |
| a_addr | input | AW | Port A address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable |
| a_be | input | LANES | Port A byte-lane enables |
| a_stall | input | 1 | Port A address stall |
| a_rdata | output | LANES*LANE_W | Port A registered read data |
| b_addr | input | AW | Port B address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_re | input | 1 | Port B read enable |
| b_be | input | LANES | Port B byte-lane enables |
| b_stall | input | 1 | Port B address stall |
| b_rdata | output | LANES*LANE_W | Port B registered read data |
| coll_o | output | 1 | One-cycle pulse after a same-address double write |

## Verification
Every result of this block is due exactly one clock after the edge that samples its stimulus. This covers both read data words, the collision pulse and the stored word that a later read exposes. The bench changes the inputs on the falling edge and lets one rising edge pass. At the next falling edge it compares both read ports and the collision pulse against a model that is updated in the same step. A stalled address is carried in the model's own copy of each port's held address, so a stalled access lands one cycle later exactly where the model expects. No check waits more than one edge.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic {RDW_OLD = 1'b0, RDW_NEW = 1'b1} rdw_mode_e;

  // low bit index of a byte lane
  function automatic int lane_lo(input int lane, input int lane_w);
    return lane * lane_w;
  endfunction
endpackage

// File: rtl/tdp_addr_hold.sv
module tdp_addr_hold #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff
);
  logic [AW-1:0] held_q;

  // a stalled port reuses the address it used last cycle
  assign addr_eff = stall ? held_q : addr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= addr_eff;
  end
endmodule

// File: rtl/tdp_collide.sv
module tdp_collide #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             we_a,
  input  logic             we_b,
  input  logic [AW-1:0]    eff_a,
  input  logic [AW-1:0]    eff_b,
  input  logic [LANES-1:0] be_a,
  input  logic [LANES-1:0] be_b,
  output logic [LANES-1:0] wen_a,
  output logic [LANES-1:0] wen_b,
  output logic             hit
);
  // lanes granted to B: A keeps every lane it enables on a shared word
  function automatic logic [LANES-1:0] yield_lanes(input logic clash,
                                                   input logic [LANES-1:0] mine,
                                                   input logic [LANES-1:0] other);
    return clash ? (mine & ~other) : mine;
  endfunction

  assign hit   = we_a && we_b && (eff_a == eff_b);
  assign wen_a = we_a ? be_a : '0;
  assign wen_b = we_b ? yield_lanes(hit, be_b, be_a) : '0;
endmodule

// File: rtl/tdp_rdport.sv
module tdp_rdport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic          take_new,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] new_word,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= take_new ? new_word : old_word;
  end
endmodule

// File: rtl/tdp_array.sv
module tdp_array #(
  parameter int                 AW     = 6,
  parameter int                 LANES  = 4,
  parameter int                 LANE_W = 8,
  parameter tdp_pkg::rdw_mode_e MODE_A = tdp_pkg::RDW_NEW,
  parameter tdp_pkg::rdw_mode_e MODE_B = tdp_pkg::RDW_OLD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           eff_a,
  input  logic [AW-1:0]           eff_b,
  input  logic [LANES-1:0]        wen_a,
  input  logic [LANES-1:0]        wen_b,
  input  logic [LANES*LANE_W-1:0] wd_a,
  input  logic [LANES*LANE_W-1:0] wd_b,
  input  logic                    we_a,
  input  logic                    we_b,
  input  logic                    re_a,
  input  logic                    re_b,
  output logic [LANES*LANE_W-1:0] q_a,
  output logic [LANES*LANE_W-1:0] q_b
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] old_a, old_b, post_a, post_b;

  // contents of word x once this edge's granted lanes land
  function automatic logic [DW-1:0] after_write(input logic [DW-1:0] cur,
                                                input logic [AW-1:0] x,
                                                input logic [AW-1:0] ea,
                                                input logic [AW-1:0] eb,
                                                input logic [LANES-1:0] ga,
                                                input logic [LANES-1:0] gb,
                                                input logic [DW-1:0] da,
                                                input logic [DW-1:0] db);
    logic [DW-1:0] w;
    w = cur;
    for (int l = 0; l < LANES; l++) begin
      if (ga[l] && ea == x)      w[tdp_pkg::lane_lo(l, LANE_W) +: LANE_W] = da[tdp_pkg::lane_lo(l, LANE_W) +: LANE_W];
      else if (gb[l] && eb == x) w[tdp_pkg::lane_lo(l, LANE_W) +: LANE_W] = db[tdp_pkg::lane_lo(l, LANE_W) +: LANE_W];
    end
    return w;
  endfunction

  assign old_a  = mem[eff_a];
  assign old_b  = mem[eff_b];
  assign post_a = after_write(old_a, eff_a, eff_a, eff_b, wen_a, wen_b, wd_a, wd_b);
  assign post_b = after_write(old_b, eff_b, eff_a, eff_b, wen_a, wen_b, wd_a, wd_b);

  // grants are disjoint on a shared word, so the order here is irrelevant
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wen_b[l]) mem[eff_b][tdp_pkg::lane_lo(l, LANE_W) +: LANE_W] <= wd_b[tdp_pkg::lane_lo(l, LANE_W) +: LANE_W];
      if (wen_a[l]) mem[eff_a][tdp_pkg::lane_lo(l, LANE_W) +: LANE_W] <= wd_a[tdp_pkg::lane_lo(l, LANE_W) +: LANE_W];
    end
  end

  tdp_rdport #(.DW(DW)) u_rd_a (
    .clk(clk), .rst_n(rst_n), .re(re_a),
    .take_new((MODE_A == tdp_pkg::RDW_NEW) && we_a),
    .old_word(old_a), .new_word(post_a), .q(q_a));

  tdp_rdport #(.DW(DW)) u_rd_b (
    .clk(clk), .rst_n(rst_n), .re(re_b),
    .take_new((MODE_B == tdp_pkg::RDW_NEW) && we_b),
    .old_word(old_b), .new_word(post_b), .q(q_b));
endmodule

// File: rtl/tdp_ram_arb.sv
module tdp_ram_arb #(
  parameter int                 AW     = 6,
  parameter int                 LANES  = 4,
  parameter int                 LANE_W = 8,
  parameter tdp_pkg::rdw_mode_e MODE_A = tdp_pkg::RDW_NEW,
  parameter tdp_pkg::rdw_mode_e MODE_B = tdp_pkg::RDW_OLD
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           a_addr,
  input  logic [LANES*LANE_W-1:0] a_wdata,
  input  logic                    a_we,
  input  logic                    a_re,
  input  logic [LANES-1:0]        a_be,
  input  logic                    a_stall,
  output logic [LANES*LANE_W-1:0] a_rdata,
  input  logic [AW-1:0]           b_addr,
  input  logic [LANES*LANE_W-1:0] b_wdata,
  input  logic                    b_we,
  input  logic                    b_re,
  input  logic [LANES-1:0]        b_be,
  input  logic                    b_stall,
  output logic [LANES*LANE_W-1:0] b_rdata,
  output logic                    coll_o
);
  // named internal events, observed by the bound checker
  logic [AW-1:0]    eff_a, eff_b;
  logic [LANES-1:0] wen_a, wen_b;
  logic             clash;

  tdp_addr_hold #(.AW(AW)) u_hold_a (
    .clk(clk), .rst_n(rst_n), .stall(a_stall), .addr_in(a_addr), .addr_eff(eff_a));
  tdp_addr_hold #(.AW(AW)) u_hold_b (
    .clk(clk), .rst_n(rst_n), .stall(b_stall), .addr_in(b_addr), .addr_eff(eff_b));

  tdp_collide #(.AW(AW), .LANES(LANES)) u_coll (
    .we_a(a_we), .we_b(b_we), .eff_a(eff_a), .eff_b(eff_b),
    .be_a(a_be), .be_b(b_be), .wen_a(wen_a), .wen_b(wen_b), .hit(clash));

  tdp_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .MODE_A(MODE_A), .MODE_B(MODE_B)) u_mem (
    .clk(clk), .rst_n(rst_n), .eff_a(eff_a), .eff_b(eff_b),
    .wen_a(wen_a), .wen_b(wen_b), .wd_a(a_wdata), .wd_b(b_wdata),
    .we_a(a_we), .we_b(b_we), .re_a(a_re), .re_b(b_re),
    .q_a(a_rdata), .q_b(b_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coll_o <= 1'b0;
    else        coll_o <= clash;
  end
endmodule

// File: rtl/tdp_ram_arb_chk.sv
module tdp_ram_arb_chk #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_we,
  input logic             b_we,
  input logic             a_re,
  input logic             b_re,
  input logic [LANES-1:0] a_be,
  input logic [DW-1:0]    a_rdata,
  input logic [DW-1:0]    b_rdata,
  input logic             coll_o,
  input logic [AW-1:0]    eff_a,
  input logic [AW-1:0]    eff_b,
  input logic [LANES-1:0] wen_a,
  input logic [LANES-1:0] wen_b
);
  AST_COLL_RAISE:  assert property (@(posedge clk) disable iff (!rst_n) (a_we && b_we && eff_a == eff_b) |=> coll_o); // R6
  AST_COLL_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !(a_we && b_we && eff_a == eff_b) |=> !coll_o); // R6
  AST_A_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !a_re |=> $stable(a_rdata)); // R4
  AST_B_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !b_re |=> $stable(b_rdata)); // R4
  AST_LANES_SPLIT: assert property (@(posedge clk) disable iff (!rst_n) (a_we && b_we && eff_a == eff_b) |-> $countones(wen_a & wen_b) == 0); // R5
  AST_A_FIRST:     assert property (@(posedge clk) disable iff (!rst_n) a_we |-> wen_a == a_be); // R5
endmodule

bind tdp_ram_arb tdp_ram_arb_chk #(.AW(AW), .LANES(LANES), .DW(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_we(a_we), .b_we(b_we), .a_re(a_re), .b_re(b_re),
  .a_be(a_be), .a_rdata(a_rdata), .b_rdata(b_rdata), .coll_o(coll_o),
  .eff_a(eff_a), .eff_b(eff_b), .wen_a(wen_a), .wen_b(wen_b));

// File: tb/sim_tdp_ram_arb.sv
module sim_tdp_ram_arb;
  localparam int AW = 3, LANES = 2, LANE_W = 8;
  localparam int DW = LANES * LANE_W, DEPTH = 1 << AW;
  localparam bit NEW_A = 1'b1, NEW_B = 1'b0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic a_we = 0, b_we = 0, a_re = 0, b_re = 0, a_stall = 0, b_stall = 0, coll_o;
  logic [LANES-1:0] a_be = '0, b_be = '0;

  always #4 clk = ~clk; // 125 MHz

  tdp_ram_arb #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W),
                .MODE_A(tdp_pkg::RDW_NEW), .MODE_B(tdp_pkg::RDW_OLD)) u0 (.*);

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [DW-1:0] m [DEPTH];
  logic [AW-1:0] hold_a = '0, hold_b = '0;
  logic [DW-1:0] xq_a = '0, xq_b = '0;

  task automatic chk(input string req, input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // model: the word at x after this cycle's writes, A overriding B lane by lane
  function automatic logic [DW-1:0] merged(input logic [AW-1:0] x, input logic [AW-1:0] ea, input logic [AW-1:0] eb);
    logic [DW-1:0] w = m[x];
    for (int l = 0; l < LANES; l++) begin
      if (b_we && eb == x && b_be[l]) w[l*LANE_W +: LANE_W] = b_wdata[l*LANE_W +: LANE_W];
      if (a_we && ea == x && a_be[l]) w[l*LANE_W +: LANE_W] = a_wdata[l*LANE_W +: LANE_W];
    end
    return w;
  endfunction

  // inputs already driven at a falling edge; one rising edge, then compare
  task automatic step(input string req);
    logic [AW-1:0] ea, eb;
    logic [DW-1:0] na, nb;
    logic xc;
    ea = a_stall ? hold_a : a_addr;
    eb = b_stall ? hold_b : b_addr;
    na = merged(ea, ea, eb);
    nb = merged(eb, ea, eb);
    if (a_re) xq_a = (NEW_A && a_we) ? na : m[ea];
    if (b_re) xq_b = (NEW_B && b_we) ? nb : m[eb];
    xc = a_we && b_we && ea == eb;
    m[eb] = nb;
    m[ea] = na;
    hold_a = ea;
    hold_b = eb;
    @(posedge clk);
    @(negedge clk);
    chk(req, "a_rdata", a_rdata, xq_a);
    chk(req, "b_rdata", b_rdata, xq_b);
    chk("R6", "coll_o", {{(DW-1){1'b0}}, coll_o}, {{(DW-1){1'b0}}, xc});
  endtask

  task automatic idle();
    a_we = 0; b_we = 0; a_re = 0; b_re = 0; a_stall = 0; b_stall = 0;
    a_be = '1; b_be = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "a_rdata", a_rdata, '0);
    chk("R1", "b_rdata", b_rdata, '0);
    chk("R1", "coll_o", {{(DW-1){1'b0}}, coll_o}, '0);
    rst_n = 1'b1;
    step("R1");

    // R10: both ports fill distinct halves in the same cycles
    for (int i = 0; i < DEPTH / 2; i++) begin
      idle(); a_we = 1; b_we = 1;
      a_addr = AW'(i); b_addr = AW'(i + DEPTH / 2);
      a_wdata = DW'(16'h1111 * (i + 1)); b_wdata = DW'(16'h0F0F ^ (i * 16'h0101));
      step("R10");
    end
    // R2: read sweep, opposite directions
    for (int i = 0; i < DEPTH; i++) begin
      idle(); a_re = 1; b_re = 1; a_addr = AW'(i); b_addr = AW'(DEPTH - 1 - i);
      step("R2");
    end
    // R3: every byte-enable pattern, each followed by a readback
    for (int e = 0; e < (1 << LANES); e++) begin
      idle(); a_we = 1; a_addr = 3'd1; a_be = LANES'(e); a_wdata = DW'(16'hA5C3 + e);
      step("R3");
      idle(); b_re = 1; b_addr = 3'd1;
      step("R3");
    end
    // R4: writes with read enable low leave both outputs untouched
    idle(); a_we = 1; b_we = 1; a_addr = 3'd2; b_addr = 3'd6; a_wdata = 16'hDEAD; b_wdata = 16'hBEEF;
    step("R4");
    idle(); a_addr = 3'd5; b_addr = 3'd0;
    step("R4");
    // R5: same-address double writes, all lane combinations
    for (int ea = 0; ea < (1 << LANES); ea++)
      for (int eb = 0; eb < (1 << LANES); eb++) begin
        idle(); a_we = 1; b_we = 1; a_re = 1; b_re = 1; a_addr = 3'd5; b_addr = 3'd5;
        a_be = LANES'(ea); b_be = LANES'(eb);
        a_wdata = DW'(16'h1200 + ea * 16 + eb); b_wdata = DW'(16'h00CD ^ (eb * 16'h1010));
        step("R5");
        idle(); a_re = 1; a_addr = 3'd5;
        step("R5");
      end
    // R7: mixed-port read of a word being written, both directions
    idle(); a_we = 1; a_addr = 3'd2; a_wdata = 16'h7E57; b_re = 1; b_addr = 3'd2;
    step("R7");
    idle(); b_we = 1; b_addr = 3'd4; b_wdata = 16'h4242; a_re = 1; a_addr = 3'd4;
    step("R7");
    // R8: same-port read during write, A new-data, B old-data
    idle(); a_we = 1; a_re = 1; a_addr = 3'd3; a_be = 2'b01; a_wdata = 16'h9988;
    b_we = 1; b_re = 1; b_addr = 3'd7; b_wdata = 16'h6655;
    step("R8");
    idle(); a_re = 1; b_re = 1; a_addr = 3'd7; b_addr = 3'd3;
    step("R8");
    // R9: stall holds each port's address against a changing input
    idle(); a_re = 1; b_re = 1; a_addr = 3'd6; b_addr = 3'd1;
    step("R9");
    idle(); a_stall = 1; b_stall = 1; a_we = 1; a_re = 1; b_re = 1;
    a_addr = 3'd0; b_addr = 3'd4; a_wdata = 16'h5A5A;
    step("R9");
    idle(); a_stall = 1; a_re = 1; b_re = 1; a_addr = 3'd2; b_addr = 3'd6;
    step("R9");
    // random traffic with frequent collisions
    for (int n = 0; n < 3000; n++) begin
      a_addr = AW'($urandom); b_addr = AW'($urandom);
      a_wdata = DW'($urandom); b_wdata = DW'($urandom);
      a_be = LANES'($urandom); b_be = LANES'($urandom);
      a_we = 1'($urandom); b_we = 1'($urandom);
      a_re = 1'($urandom); b_re = 1'($urandom);
      a_stall = ($urandom % 5) == 0; b_stall = ($urandom % 5) == 0;
      step("R5");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule